// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one byte from the host to a PS/2 device over the two open-drain bus lines. It accepts a byte over a valid/ready handshake. It then holds the clock line low for a fixed inhibit interval, pulls the data line low as the start bit and lets the clock go. From that point the device supplies the clock. On each qualified falling edge of that clock the block presents the next bit: eight data bits with the least significant bit first, an odd-parity bit, and then a released data line as the stop bit. On the edge after the stop bit it reads the device's acknowledge.

Clock edges that arrive too soon after the clock is released, or too close to the previous accepted edge, are treated as noise and ignored. An over-long gap between edges, a negative acknowledge or a bit position that runs past the acknowledge all cause the same byte to be sent again, starting from the inhibit step. A watchdog limits the total transfer time. Both line outputs are active-high pull-low enables meant to drive open-drain pads. Every interval is given in system clock cycles through a parameter.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `in_ready` is 1, `ps2_clk_pull` and `ps2_dat_pull` are 0, and `done` is 0.
- R2: A byte is taken when `in_valid` and `in_ready` are both 1. From the next cycle `ps2_clk_pull` is 1 for exactly INHIBIT_CYC cycles with the data line released. In the cycle the clock is let go, `ps2_dat_pull` becomes 1 (start bit 0).
- R3: On each accepted falling edge of the synchronized clock line, the first eight edges put the data bits on the line LSB first. A 0 bit drives `ps2_dat_pull`=1 and a 1 bit drives `ps2_dat_pull`=0.
- R4: The ninth accepted edge puts the parity bit on the line. Its value makes the count of ones over the eight data bits and the parity bit odd.
- R5: The tenth accepted edge releases the data line (stop bit = 1). The line stays released until the acknowledge is sampled.
- R6: On the eleventh accepted edge a low data line ends the transfer. `done` is 1 for exactly one cycle with `done_status`=0 (ok), and in that cycle `in_ready` is 1 and both pulls are 0.
- R7: A high data line at the acknowledge edge is a negative acknowledge. The block re-enters the inhibit step and sends the same byte again, and it gives no `done` for the failed attempt.
- R8: A falling edge that comes fewer than MIN_GAP_CYC cycles after the last accepted edge is ignored.
- R9: A falling edge that comes fewer than IGNORE_CYC cycles after the clock is released is ignored.
- R10: Once past the first data bit, an edge that comes more than MAX_GAP_CYC cycles after the last accepted edge causes a resend from the inhibit step. The first data edge is exempt from this limit.
- R11: If TIMEOUT_CYC cycles pass after the byte is taken without success, `done` pulses with `done_status`=1, both lines are released and the block goes idle. If a good acknowledge lands in the expiry cycle, the acknowledge wins.
- R12: While a transfer is in progress `in_ready` is 0 and `in_valid` has no effect on the byte being sent.
- R13: The bit position starts at the first data bit, because the start bit belongs to the inhibit step. It never passes the acknowledge position, and if it somehow does, the block releases data and resends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered for transmission |
| in_byte | input | 8 | Byte to transmit |
| in_ready | output | 1 | Block idle and able to take a byte |
| ps2_clk_i | input | 1 | Sensed level of the bus clock line (asynchronous) |
| ps2_dat_i | input | 1 | Sensed level of the bus data line (asynchronous) |
| ps2_clk_pull | output | 1 | 1 pulls the bus clock line low |
| ps2_dat_pull | output | 1 | 1 pulls the bus data line low |
| done | output | 1 | One-cycle end-of-transfer strobe |
| done_status | output | 1 | Result with `done`: 0 ok, 1 timeout |

## Verification
The overall transfer watchdog and the acknowledge sample can fall in the same cycle. When they do, one of them must win cleanly, with one `done` strobe and not two, and the lines must be left released. The bench provokes this by sweeping the idle time before the device's first clock edge one cycle at a time, so the acknowledge edge moves across the watchdog's expiry. In every run it counts exactly one strobe, checks that the bus is free afterwards, and checks the frame contents whenever the result is ok. It also requires that the sweep produced both outcomes.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_INHIBIT = 2'd1,
        TX_FRAME   = 2'd2
    } tx_state_e;

    typedef enum logic {
        XFER_OK      = 1'b0,
        XFER_TIMEOUT = 1'b1
    } xfer_status_e;

    localparam int unsigned POS_W = 4;
    typedef logic [POS_W-1:0] pos_t;

    // Bit positions of a host-to-device frame, counted by accepted edges
    localparam pos_t POS_DATA0  = pos_t'(1);
    localparam pos_t POS_PARITY = pos_t'(9);
    localparam pos_t POS_STOP   = pos_t'(10);
    localparam pos_t POS_ACK    = pos_t'(11);

    // Working context of one transfer
    typedef struct packed {
        logic [7:0] data;
        pos_t       pos;
        logic       clk_pull;
        logic       dat_pull;
    } tx_ctx_t;

    // Parity bit that makes the nine-bit total of ones odd
    function automatic logic odd_parity(input logic [7:0] b);
        return ~^b;
    endfunction

    // Pull-low enable that presents the bit belonging to position p
    function automatic logic pull_for_pos(input logic [7:0] b, input pos_t p);
        logic level;
        if (p == POS_PARITY) level = odd_parity(b);
        else                 level = b[3'(p - POS_DATA0)];
        return ~level;
    endfunction

endpackage

// File: rtl/ps2tx_line_sync.sv
module ps2tx_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    // Idle bus lines float high, so the chain resets to ones
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '1;
                else     stage_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '1;
                else     stage_q <= {stage_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ps2tx_edge_qual.sv
module ps2tx_edge_qual #(
    parameter int unsigned IGNORE_CYC  = 3000,
    parameter int unsigned MIN_GAP_CYC = 2000,
    parameter int unsigned MAX_GAP_CYC = 6000
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_level,   // synchronized bus clock
    input  logic restart,     // clock just released by the host
    input  logic past_first,  // first data bit already placed
    output logic edge_take,
    output logic edge_late
);
    localparam int unsigned REL_W   = $clog2(IGNORE_CYC + 1);
    localparam int unsigned GAP_SAT = MAX_GAP_CYC + 1;
    localparam int unsigned GAP_W   = $clog2(GAP_SAT + 1);
    localparam logic [REL_W-1:0] REL_LIM = REL_W'(IGNORE_CYC);
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_GAP_CYC);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MAX_GAP_CYC);
    localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_SAT);

    logic             prev_q;
    logic [REL_W-1:0] rel_cnt_q;
    logic [GAP_W-1:0] gap_cnt_q;
    logic             fall, early, spur, late;

    assign fall  = prev_q & ~clk_level;
    assign early = rel_cnt_q < REL_LIM;
    assign spur  = gap_cnt_q < GAP_MIN;
    assign late  = gap_cnt_q > GAP_MAX;

    assign edge_late = fall & ~early & late & past_first;
    assign edge_take = fall & ~early & ~(late & past_first) & ~spur;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b1;
            rel_cnt_q <= '0;
            gap_cnt_q <= '0;
        end else begin
            prev_q <= clk_level;
            if (restart)                rel_cnt_q <= '0;
            else if (rel_cnt_q != REL_LIM) rel_cnt_q <= rel_cnt_q + 1'b1;
            if (restart || edge_take)   gap_cnt_q <= '0;
            else if (gap_cnt_q != GAP_TOP) gap_cnt_q <= gap_cnt_q + 1'b1;
        end
    end

    AST_NO_BACK_TO_BACK_TAKE: assert property (@(posedge clk) disable iff (rst)
        edge_take |=> !edge_take);  // R8

    AST_NO_TAKE_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> !edge_take && !edge_late);  // R9

endmodule

// File: rtl/ps2tx_xfer_timer.sv
module ps2tx_xfer_timer #(
    parameter int unsigned LIMIT_CYC = 500_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    localparam int unsigned CNT_W = $clog2(LIMIT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active)   cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = active && (cnt_q == LAST);

    AST_EXPIRY_ENDS_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        expire |=> !active);  // R11

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
    import ps2tx_pkg::*;
#(
    parameter int unsigned INHIBIT_CYC = 10000,
    parameter int unsigned IGNORE_CYC  = 3000,
    parameter int unsigned MIN_GAP_CYC = 2000,
    parameter int unsigned MAX_GAP_CYC = 6000,
    parameter int unsigned TIMEOUT_CYC = 500_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ps2_clk_pull,
    output logic       ps2_dat_pull,
    output logic       done,
    output logic       done_status
);
    localparam int unsigned INH_W = $clog2(INHIBIT_CYC + 1);
    localparam logic [INH_W-1:0] INH_LAST = INH_W'(INHIBIT_CYC - 1);

    tx_state_e        state_q, state_d;
    tx_ctx_t          ctx_q, ctx_d;
    logic [INH_W-1:0] inh_q, inh_d;
    logic             done_q, done_d;
    xfer_status_e     status_q, status_d;

    logic [1:0] line_sync;
    logic       clk_s, dat_s;
    logic       restart, past_first, in_frame;
    logic       q_take, q_late, take, late, ack_ok, wd_expire;
    logic       do_retry, do_finish;
    xfer_status_e fin_status;

    ps2tx_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ps2_clk_i, ps2_dat_i}),
        .sync_out (line_sync)
    );
    assign clk_s = line_sync[1];
    assign dat_s = line_sync[0];

    assign in_frame   = (state_q == TX_FRAME);
    assign restart    = (state_q == TX_INHIBIT) && (inh_q == INH_LAST);
    assign past_first = ctx_q.pos > POS_DATA0;

    ps2tx_edge_qual #(
        .IGNORE_CYC  (IGNORE_CYC),
        .MIN_GAP_CYC (MIN_GAP_CYC),
        .MAX_GAP_CYC (MAX_GAP_CYC)
    ) u_qual (
        .clk        (clk),
        .rst        (rst),
        .clk_level  (clk_s),
        .restart    (restart),
        .past_first (past_first),
        .edge_take  (q_take),
        .edge_late  (q_late)
    );

    ps2tx_xfer_timer #(.LIMIT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (state_q != TX_IDLE),
        .expire (wd_expire)
    );

    assign take   = q_take & in_frame;
    assign late   = q_late & in_frame;
    assign ack_ok = take && (ctx_q.pos == POS_ACK) && !dat_s;

    always_comb begin
        state_d    = state_q;
        ctx_d      = ctx_q;
        inh_d      = inh_q;
        done_d     = 1'b0;
        status_d   = status_q;
        do_retry   = 1'b0;
        do_finish  = 1'b0;
        fin_status = XFER_OK;

        unique case (state_q)
            TX_IDLE: begin
                if (in_valid) begin
                    ctx_d.data     = in_byte;
                    ctx_d.pos      = POS_DATA0;
                    ctx_d.clk_pull = 1'b1;
                    ctx_d.dat_pull = 1'b0;
                    inh_d          = '0;
                    state_d        = TX_INHIBIT;
                end
            end
            TX_INHIBIT: begin
                if (wd_expire) begin
                    do_finish  = 1'b1;
                    fin_status = XFER_TIMEOUT;
                end else if (restart) begin
                    ctx_d.clk_pull = 1'b0;
                    ctx_d.dat_pull = 1'b1;   // start bit
                    ctx_d.pos      = POS_DATA0;
                    state_d        = TX_FRAME;
                end else begin
                    inh_d = inh_q + 1'b1;
                end
            end
            TX_FRAME: begin
                if (wd_expire && !ack_ok) begin
                    do_finish  = 1'b1;
                    fin_status = XFER_TIMEOUT;
                end else if (late) begin
                    do_retry = 1'b1;
                end else if (take) begin
                    if (ctx_q.pos <= POS_PARITY) begin
                        ctx_d.dat_pull = pull_for_pos(ctx_q.data, ctx_q.pos);
                        ctx_d.pos      = ctx_q.pos + pos_t'(1);
                    end else if (ctx_q.pos == POS_STOP) begin
                        ctx_d.dat_pull = 1'b0;
                        ctx_d.pos      = ctx_q.pos + pos_t'(1);
                    end else if (ack_ok) begin
                        do_finish  = 1'b1;
                        fin_status = XFER_OK;
                    end else begin
                        do_retry = 1'b1;      // NACK or out of sync
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase

        if (do_retry) begin
            ctx_d.clk_pull = 1'b1;
            ctx_d.dat_pull = 1'b0;
            ctx_d.pos      = POS_DATA0;
            inh_d          = '0;
            state_d        = TX_INHIBIT;
        end
        if (do_finish) begin
            ctx_d.clk_pull = 1'b0;
            ctx_d.dat_pull = 1'b0;
            done_d         = 1'b1;
            status_d       = fin_status;
            state_d        = TX_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TX_IDLE;
            ctx_q    <= '{data: 8'h00, pos: POS_DATA0, clk_pull: 1'b0, dat_pull: 1'b0};
            inh_q    <= '0;
            done_q   <= 1'b0;
            status_q <= XFER_OK;
        end else begin
            state_q  <= state_d;
            ctx_q    <= ctx_d;
            inh_q    <= inh_d;
            done_q   <= done_d;
            status_q <= status_d;
        end
    end

    assign in_ready     = (state_q == TX_IDLE);
    assign ps2_clk_pull = ctx_q.clk_pull;
    assign ps2_dat_pull = ctx_q.dat_pull;
    assign done         = done_q;
    assign done_status  = status_q;

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !ps2_clk_pull && !ps2_dat_pull);  // R1

    AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($fell(ps2_clk_pull) && !in_ready) |-> ps2_dat_pull);  // R2

    AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_FRAME && ctx_q.pos == POS_ACK) |-> !ps2_dat_pull);  // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R6

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready);  // R6

    AST_NACK_RESENDS: assert property (@(posedge clk) disable iff (rst)
        (take && ctx_q.pos == POS_ACK && dat_s && !wd_expire) |=> ps2_clk_pull && !done);  // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready && ps2_clk_pull);  // R12

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_FRAME) |-> (ctx_q.pos >= POS_DATA0 && ctx_q.pos <= POS_ACK));  // R13

endmodule

// File: tb/test_ps2_host_tx.sv
module test_ps2_host_tx;

    localparam int INH  = 20;
    localparam int IGN  = 12;
    localparam int MING = 10;
    localparam int MAXG = 24;
    localparam int TO   = 3000;

    localparam int M_GOOD   = 0;
    localparam int M_NACK   = 1;
    localparam int M_GLITCH = 2;
    localparam int M_EARLY  = 3;
    localparam int M_LONG   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic       in_valid = 1'b0;
    logic [7:0] in_byte  = 8'h00;
    logic       dev_clk_low = 1'b0;
    logic       dev_dat_low = 1'b0;
    wire        in_ready, clk_pull, dat_pull, done, done_status;
    wire        clk_line = ~(clk_pull | dev_clk_low);
    wire        dat_line = ~(dat_pull | dev_dat_low);

    ps2_host_tx #(
        .INHIBIT_CYC (INH),
        .IGNORE_CYC  (IGN),
        .MIN_GAP_CYC (MING),
        .MAX_GAP_CYC (MAXG),
        .TIMEOUT_CYC (TO),
        .SYNC_STAGES (2)
    ) i_ps2_host_tx (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_ready     (in_ready),
        .ps2_clk_i    (clk_line),
        .ps2_dat_i    (dat_line),
        .ps2_clk_pull (clk_pull),
        .ps2_dat_pull (dat_pull),
        .done         (done),
        .done_status  (done_status)
    );

    int   n_chk = 0;
    int   n_err = 0;
    int   done_cnt = 0;
    logic last_status = 1'b0;

    always @(negedge clk) begin
        if (!rst && done) begin
            done_cnt    <= done_cnt + 1;
            last_status <= done_status;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    // Expected line levels for data bits, parity and stop
    function automatic logic [9:0] frame_expect(input logic [7:0] b);
        logic p;
        p = 1'b1;
        for (int i = 0; i < 8; i++) p = p ^ b[i];
        return {1'b1, p, b};
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Waits for the clock inhibit, measures it and checks the start bit
    task automatic wait_release(input bit exact, input string req);
        int g;
        int len;
        g = 0;
        len = 0;
        while (!clk_pull && g < 400) begin tick(1); g++; end
        while (clk_pull && len < 400) begin tick(1); len++; end
        if (exact) chk({req, " inhibit length"}, len, INH);
        else       chk({req, " inhibit seen"}, (len > 0) ? 1 : 0, 1);
        chk({req, " start bit pulls data at release"}, dat_pull, 1);
    endtask

    // Device-side model: clocks a frame and samples the host's bits
    task automatic dev_frame(input int mode, input int lo, input int hi,
                             input int w, output logic [9:0] got);
        got = '0;
        if (mode == M_EARLY) begin
            tick(3);
            dev_clk_low = 1'b1; tick(2); dev_clk_low = 1'b0;
            tick(w - 5);
        end else begin
            tick(w);
        end
        for (int k = 1; k <= 11; k++) begin
            if (k == 4 && mode == M_LONG) begin
                tick(30);
                dev_clk_low = 1'b1; tick(2); dev_clk_low = 1'b0;
                return;
            end
            if (k == 11) dev_dat_low = (mode != M_NACK);
            dev_clk_low = 1'b1;
            tick(lo);
            if (k <= 10) got[k-1] = dat_line;
            dev_clk_low = 1'b0;
            if (k == 11) dev_dat_low = 1'b0;
            if (k == 3 && mode == M_GLITCH) begin
                tick(1); dev_clk_low = 1'b1; tick(1); dev_clk_low = 1'b0; tick(hi - 2);
            end else begin
                tick(hi);
            end
        end
    endtask

    task automatic check_good_end(input logic [7:0] b, input logic [9:0] got,
                                  input int d0, input string tag);
        logic [9:0] e;
        e = frame_expect(b);
        chk({"R3 data bits LSB first ", tag}, int'(got[7:0]), int'(e[7:0]));
        chk({"R4 odd parity ", tag}, got[8], e[8]);
        chk({"R5 stop released ", tag}, got[9], 1);
        chk({"R6 single done ", tag}, done_cnt - d0, 1);
        chk({"R6 status ok ", tag}, last_status, 0);
        chk({"R6 idle lines free ", tag}, {in_ready, clk_pull, dat_pull}, 3'b100);
    endtask

    task automatic run_frame(input logic [7:0] b, input int mode, input int lo,
                             input int hi, input int w, input bit poke, input string tag);
        logic [9:0] got;
        int d0;
        d0 = done_cnt;
        send(b);
        wait_release(1'b1, "R2");
        if (poke) begin
            chk("R12 ready low while busy", in_ready, 0);
            in_valid = 1'b1; in_byte = ~b;
            tick(1);
            in_valid = 1'b0;
            dev_frame(mode, lo, hi, w - 1, got);
        end else begin
            dev_frame(mode, lo, hi, w, got);
        end
        tick(4);
        check_good_end(b, got, d0, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [9:0] got;
        int d0;
        int cyc;
        int saw_ok;
        int saw_to;
        void'($urandom(32'd4242));

        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 clock released after reset", clk_pull, 0);
        chk("R1 data released after reset", dat_pull, 0);
        chk("R1 no done after reset", done, 0);

        // Directed frames
        run_frame(8'hA5, M_GOOD, 8, 8, 20, 1'b1, "R12 busy poke");
        run_frame(8'h00, M_GOOD, 6, 6, 20, 1'b0, "all zero");
        run_frame(8'hFF, M_GOOD, 10, 10, 20, 1'b0, "all one");
        run_frame(8'h80, M_GLITCH, 6, 8, 20, 1'b0, "R8 glitch");
        run_frame(8'h3C, M_EARLY, 8, 8, 20, 1'b0, "R9 early edge");

        // R7: negative acknowledge then resend of the same byte
        d0 = done_cnt;
        send(8'h5B);
        wait_release(1'b1, "R7 first");
        dev_frame(M_NACK, 8, 8, 20, got);
        wait_release(1'b0, "R7 resend");
        chk("R7 no done on NACK", done_cnt - d0, 0);
        dev_frame(M_GOOD, 8, 8, 20, got);
        tick(4);
        check_good_end(8'h5B, got, d0, "R7 resend");

        // R10: long gap past first data bit forces a resend
        d0 = done_cnt;
        send(8'hC3);
        wait_release(1'b1, "R10 first");
        dev_frame(M_LONG, 8, 8, 20, got);
        wait_release(1'b0, "R10 resend");
        chk("R10 no done on gap error", done_cnt - d0, 0);
        dev_frame(M_GOOD, 8, 8, 20, got);
        tick(4);
        check_good_end(8'hC3, got, d0, "R10 resend");

        // R10: long wait before the first data edge is allowed
        run_frame(8'h71, M_GOOD, 8, 8, 80, 1'b0, "R10 first edge exempt");

        // R11: silent device, transfer times out
        d0 = done_cnt;
        send(8'h12);
        cyc = 1;
        while (!done && cyc < TO + 50) begin tick(1); cyc++; end
        chk("R11 timeout near limit", (cyc >= TO && cyc <= TO + 2) ? 1 : 0, 1);
        tick(2);
        chk("R11 single done", done_cnt - d0, 1);
        chk("R11 status timeout", last_status, 1);
        chk("R11 idle lines free", {in_ready, clk_pull, dat_pull}, 3'b100);

        // R11: acknowledge swept across the watchdog expiry
        saw_ok = 0;
        saw_to = 0;
        for (int j = -15; j <= 10; j++) begin
            d0 = done_cnt;
            send(8'h96);
            wait_release(1'b1, "R11 sweep");
            dev_frame(M_GOOD, 8, 8, TO - INH - 160 + j, got);
            tick(20);
            chk("R11 sweep single done", done_cnt - d0, 1);
            chk("R11 sweep lines free", {in_ready, clk_pull, dat_pull}, 3'b100);
            if (last_status == 1'b0) begin
                saw_ok++;
                chk("R11 sweep ok frame bits", int'(got), int'(frame_expect(8'h96)));
            end else begin
                saw_to++;
            end
        end
        chk("R11 sweep reached both outcomes", (saw_ok > 0 && saw_to > 0) ? 1 : 0, 1);

        // Random bytes and device clock shapes
        for (int n = 0; n < 24; n++) begin
            logic [7:0] b;
            int lo;
            int hi;
            int w;
            b  = 8'($urandom);
            lo = int'($urandom_range(10, 6));
            hi = int'($urandom_range(10, 6));
            w  = int'($urandom_range(40, 20));
            run_frame(b, M_GOOD, lo, hi, w, 1'b0, "random");
        end

        finish_run();
    end

endmodule